// File: doc/BRIEF.md
# Coherent 64-bit Cycle Counter with Snapshot Capture

This block keeps a free-running count of clock cycles in a 64-bit register and makes it visible through a 32-bit register bus. Software cannot read 64 bits in one access. To work around that, a single control write freezes the whole count into a snapshot register. Software then reads the two 32-bit halves of the snapshot at its own pace. Because the halves come from the frozen copy and not from the running count, they always belong to the same instant, even if the low half carries into the high half between the two reads.

The same control register can also restart the count from zero. When the clear and capture bits are set in the same write, the snapshot keeps the value from just before the clear. This lets software measure an interval and start the next one with a single write.

The bus has separate write and read strobes. A read request returns its data one cycle later, together with a one-cycle valid pulse. The read path applies no back-pressure: a read is never stalled or refused, and the data is not held beyond its valid cycle. All widths are parameters, and the count is always twice the bus width.

Top module: `cyc_snapshot_counter`

## Requirements
- R1: A synchronous reset sets the counter and the snapshot to zero and keeps `rd_valid` low. A read issued after reset and before any capture returns zero at both offsets.
- R2: Outside a clear, the counter increases by exactly one on every clock.
- R3: A write to offset 0x14 with bit 0 set clears the counter. The counter holds zero in the cycle after the write, and counting resumes from there.
- R4: A write to offset 0x14 with bit 0 clear does not disturb the counter.
- R5: A write to offset 0x14 with bit 1 set loads the snapshot with the counter value present during the write cycle. Without such a write, the snapshot does not change.
- R6: A read of offset 0x14 returns snapshot bits [31:0], and a read of offset 0x18 returns bits [63:32]. Any other offset reads as zero. Data and a one-cycle `rd_valid` pulse appear in the cycle after `rd_en`. The snapshot is returned, not the live count.
- R7: A single write to 0x14 with bits 0 and 1 both set captures the value from before the clear, and the counter restarts at zero.
- R8: Writes to offset 0x18 or to any offset other than 0x14 change neither the counter nor the snapshot.
- R9: The counter wraps from all ones to zero and keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W (8) | Write byte offset |
| wr_data | input | BUS_W (32) | Write data; bit 0 clears, bit 1 captures |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W (8) | Read byte offset |
| rd_data | output | BUS_W (32) | Read data, valid with `rd_valid` |
| rd_valid | output | 1 | One-cycle pulse, one clock after `rd_en` |

## Verification
The hardest condition to reach is the wrap from all ones to zero, because no port can preload the counter and a 64-bit count never wraps in simulation. The bench therefore runs a second, narrow instance (an 8-bit bus and a 16-bit count) beside the full-width one, on the same bus. It clears both counters, waits exactly 65536 cycles, and then captures on two consecutive edges. The two captures must read all ones and then zero on the narrow instance, and 0xFFFF and 0x10000 on the wide one. Every expected value comes from a bench model that counts clock edges since the last clear, so a capture on a same-cycle clear-and-capture write can be predicted exactly.

// File: rtl/cyc_pkg.sv
package cyc_pkg;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_LOW  = 2'd1,
    RSEL_HIGH = 2'd2
  } rsel_e;

  typedef struct packed {
    logic clear;
    logic capture;
  } ctrl_t;

  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned DEF_BUS_W  = 32;
  localparam logic [7:0]  DEF_OFS_LO = 8'h14;
  localparam logic [7:0]  DEF_OFS_HI = 8'h18;

endpackage

// File: rtl/cyc_bus_decode.sv
module cyc_bus_decode
  import cyc_pkg::*;
#(
  parameter int unsigned ADDR_W  = DEF_ADDR_W,
  parameter int unsigned BUS_W   = DEF_BUS_W,
  parameter logic [ADDR_W-1:0] OFS_LO = ADDR_W'(DEF_OFS_LO),
  parameter logic [ADDR_W-1:0] OFS_HI = ADDR_W'(DEF_OFS_HI),
  parameter int unsigned CLR_BIT = 0,
  parameter int unsigned CAP_BIT = 1
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output ctrl_t             ctrl,
  output rsel_e             rsel
);

  logic ctrl_hit;
  logic unused_wr_bits;

  // Only the control offset carries side effects; the high word is read-only.
  assign ctrl_hit = wr_en && (wr_addr == OFS_LO);

  always_comb begin
    ctrl.clear   = ctrl_hit && wr_data[CLR_BIT];
    ctrl.capture = ctrl_hit && wr_data[CAP_BIT];
  end

  always_comb begin
    if (rd_addr == OFS_LO)      rsel = RSEL_LOW;
    else if (rd_addr == OFS_HI) rsel = RSEL_HIGH;
    else                        rsel = RSEL_NONE;
  end

  assign unused_wr_bits = ^wr_data;

endmodule

// File: rtl/cyc_counter.sv
module cyc_counter #(
  parameter int unsigned CNT_W = 64,
  parameter int unsigned SEG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  output logic [CNT_W-1:0] count
);

  localparam int unsigned NSEG = CNT_W / SEG_W;

  logic [NSEG:0]      carry;
  logic [SEG_W-1:0]   seg_q [NSEG];

  assign carry[0] = 1'b1;

  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    assign carry[g+1] = carry[g] & (&seg_q[g]);
    assign count[g*SEG_W +: SEG_W] = seg_q[g];

    always_ff @(posedge clk) begin
      if (rst || clear) seg_q[g] <= '0;
      else              seg_q[g] <= seg_q[g] + SEG_W'(carry[g]);
    end
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(clear)) |-> (count == $past(count) + 1'b1));

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(clear)) |-> (count == '0));

  assert_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(clear) && $past(&count)) |-> (count == '0));

endmodule

// File: rtl/cyc_snapshot.sv
module cyc_snapshot #(
  parameter int unsigned CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [CNT_W-1:0] live,
  output logic [CNT_W-1:0] snap
);

  always_ff @(posedge clk) begin
    if (rst)          snap <= '0;
    else if (capture) snap <= live;
  end

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_snap_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(capture)) |-> $stable(snap));

  assert_snap_load_R7: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(capture)) |-> (snap == $past(live)));

endmodule

// File: rtl/cyc_read_port.sv
module cyc_read_port
  import cyc_pkg::*;
#(
  parameter int unsigned BUS_W = 32,
  parameter int unsigned CNT_W = 2 * BUS_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  rsel_e            rsel,
  input  logic [CNT_W-1:0] snap,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_valid
);

  logic [BUS_W-1:0] word;

  always_comb begin
    unique case (rsel)
      RSEL_LOW:  word = snap[BUS_W-1:0];
      RSEL_HIGH: word = snap[CNT_W-1:BUS_W];
      default:   word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= rd_en ? word : '0;
    end
  end

  assert_rd_valid_R6: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);

  assert_rd_idle_R6: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);

endmodule

// File: rtl/cyc_snapshot_counter.sv
module cyc_snapshot_counter
  import cyc_pkg::*;
#(
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned BUS_W  = DEF_BUS_W,
  parameter int unsigned SEG_W  = 16,
  parameter logic [ADDR_W-1:0] OFS_LO = ADDR_W'(DEF_OFS_LO),
  parameter logic [ADDR_W-1:0] OFS_HI = ADDR_W'(DEF_OFS_HI)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [BUS_W-1:0]  rd_data,
  output logic              rd_valid
);

  localparam int unsigned CNT_W   = 2 * BUS_W;
  localparam int unsigned CLR_BIT = 0;
  localparam int unsigned CAP_BIT = 1;

  ctrl_t            ctrl;
  rsel_e            rsel;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] snap;

  cyc_bus_decode #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .OFS_LO(OFS_LO), .OFS_HI(OFS_HI),
    .CLR_BIT(CLR_BIT), .CAP_BIT(CAP_BIT)
  ) u_decode (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .ctrl(ctrl), .rsel(rsel)
  );

  cyc_counter #(.CNT_W(CNT_W), .SEG_W(SEG_W)) u_counter (
    .clk(clk), .rst(rst), .clear(ctrl.clear), .count(count)
  );

  // Capture sees the pre-clear count: both registers update on the same edge.
  cyc_snapshot #(.CNT_W(CNT_W)) u_snapshot (
    .clk(clk), .rst(rst), .capture(ctrl.capture), .live(count), .snap(snap)
  );

  cyc_read_port #(.BUS_W(BUS_W), .CNT_W(CNT_W)) u_read (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rsel(rsel), .snap(snap),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (count == '0 && snap == '0 && !rd_valid));

  assert_no_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (past_ok && !$past(wr_en && wr_addr == OFS_LO && wr_data[CLR_BIT]))
      |-> (count == $past(count) + 1'b1));

  assert_ro_high_R8: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!(wr_en && wr_addr == OFS_LO))) |-> $stable(snap));

endmodule

// File: tb/cyc_snapshot_counter_tb.sv
module cyc_snapshot_counter_tb;

  localparam logic [7:0] LO = 8'h14;
  localparam logic [7:0] HI = 8'h18;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [7:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [7:0]  rd_data_s;
  logic        rd_valid_s;

  always #2 clk = ~clk;

  cyc_snapshot_counter u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid)
  );

  cyc_snapshot_counter #(.BUS_W(8), .SEG_W(8)) u_small (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data[7:0]),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data_s), .rd_valid(rd_valid_s)
  );

  longint unsigned ncyc = 0;
  longint unsigned base = 0;
  longint unsigned snap_m = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) ncyc <= ncyc + 1;

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d, output longint unsigned edge_idx);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    edge_idx = ncyc + 1;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic [7:0] ds);
    rd_en = 1'b1; rd_addr = a;
    @(posedge clk); @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; ds = rd_data_s;
    checks++;
    if (!(rd_valid && rd_valid_s)) begin
      errors++;
      $display("FAIL R6: actual valid=%0b/%0b expected=1/1", rd_valid, rd_valid_s);
    end
  endtask

  task automatic capture();
    longint unsigned e;
    bus_write(LO, 32'h2, e);
    snap_m = e - base - 1;
  endtask

  task automatic clear();
    longint unsigned e;
    bus_write(LO, 32'h1, e);
    base = e;
  endtask

  task automatic check_snap(input string req);
    logic [31:0] d; logic [7:0] ds;
    longint unsigned sm = snap_m & 64'hFFFF;
    bus_read(LO, d, ds);
    check(req, d, snap_m[31:0]);
    check(req, ds, sm[7:0]);
    bus_read(HI, d, ds);
    check(req, d, snap_m[63:32]);
    check(req, ds, sm[15:8]);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic [7:0] ds;
    check("R1", {rd_valid, rd_valid_s}, 0);
    bus_read(LO, d, ds); check("R1", {d, ds}, 0);
    bus_read(HI, d, ds); check("R1", {d, ds}, 0);
  endtask

  task automatic t_capture_basic();
    repeat (37) @(negedge clk);
    capture();
    check_snap("R5");
    repeat (5) @(negedge clk);
    capture();
    check_snap("R2");
  endtask

  task automatic t_coherent();
    logic [31:0] d; logic [7:0] ds;
    capture();
    repeat (60) @(negedge clk);
    bus_read(LO, d, ds);
    check("R6", d, snap_m[31:0]);
    bus_read(8'h1C, d, ds);
    check("R6", {d, ds}, 0);
  endtask

  task automatic t_clear();
    clear();
    capture();
    check_snap("R3");
    repeat (9) @(negedge clk);
    capture();
    check_snap("R3");
  endtask

  task automatic t_zero_write();
    longint unsigned e;
    bus_write(LO, 32'h0, e);
    bus_write(LO, 32'hFFFF_FFFC, e);
    capture();
    check_snap("R4");
  endtask

  task automatic t_other_offsets();
    longint unsigned e;
    logic [31:0] d; logic [7:0] ds;
    bus_write(HI, 32'h3, e);
    bus_write(8'h10, 32'h3, e);
    bus_read(LO, d, ds);
    check("R8", d, snap_m[31:0]);
    capture();
    check_snap("R8");
  endtask

  task automatic t_both();
    longint unsigned e;
    repeat (20) @(negedge clk);
    bus_write(LO, 32'h3, e);
    snap_m = e - base - 1;
    base = e;
    check_snap("R7");
    capture();
    check_snap("R7");
  endtask

  task automatic t_wrap();
    longint unsigned target;
    clear();
    target = base + 65536;
    while (ncyc + 1 < target) @(negedge clk);
    capture();
    check("R9", snap_m, 64'hFFFF);
    check_snap("R9");
    clear();
    target = base + 65536;
    while (ncyc + 1 < target) @(negedge clk);
    capture();
    capture();
    check("R9", snap_m, 64'h10000);
    check_snap("R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    base = ncyc;
    t_reset();
    t_capture_basic();
    t_coherent();
    t_clear();
    t_zero_write();
    t_other_offsets();
    t_both();
    t_wrap();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule